// File: doc/BRIEF.md
# Serial Dot and Control Register Front End

This block is the receive side of a cascadable LED matrix driver. An external host drives four slow lines: a write clock, an active-low write enable, a register-target select and a serial data line. The block samples these lines into a fast system clock and shifts the serial stream into one of two shift registers. One is a 160-bit pixel shift register. The other is an 8-bit control shift register. When the host ends a write, the block copies the shifted data into a 160-bit pixel latch or into one of two 7-bit configuration words. The refresh logic reads the latch and both words as parallel outputs.

The select line is captured at the moment the enable falls. That capture decides the destination for the whole write. The pixel latch keeps showing the old image while a new one is shifted in, so loading never disturbs the display. A serial output lets several devices share one data chain. In serial mode it carries the last stage of the shift register in use. In pass-through mode it copies the input directly, which lets one control byte reach every device in the chain at once.

Top module: `ledmx_serial_rx`

## Requirements
- R1: The level of `tgt_ctl_i` is captured when `wen_n_i` falls (0 = pixel register, 1 = control register) and holds for the whole write; later changes to `tgt_ctl_i` while `wen_n_i` is low have no effect. A write-clock rise in the same synchronised cycle as the enable fall is shifted into the newly selected register.
- R2: While `wen_n_i` is low, each rising edge of `wclk_i` shifts one bit from `sdata_i` into bit 0 of the selected shift register. The other bits move one place toward the top. Rising edges while `wen_n_i` is high shift nothing.
- R3: After a write, the transfer happens once, at the first synchronised cycle in which `wen_n_i` is high and `wclk_i` is low. If the write clock is still high when the enable rises, the transfer waits for the clock to fall.
- R4: Control data is sent MSB first, so the first of the last eight bits is D7. D7 = 0 loads D6..D0 into `cfg0_o`. D7 = 1 loads D6..D0 into `cfg1_o`. The word that is not selected keeps its value.
- R5: An active-low `rst_n` clears `cfg0_o` and `cfg1_o` to zero and leaves `dot_latch_o` unchanged.
- R6: With `cfg1_o[0]` = 0, `sdata_o` gives the top stage of the shift register chosen by the last captured select: bit 159 of the pixel register, or D7 of the control register.
- R7: With `cfg1_o[0]` = 1, `sdata_o` follows `sdata_i` combinationally while a control write is active (enable low, control selected). During pixel writes, `sdata_o` still gives bit 159 of the pixel register.
- R8: `dot_latch_o` keeps its value while a new pixel frame is being shifted in. It changes only at the transfer.
- R9: The k-th bit shifted in a 160-bit pixel write lands at `dot_latch_o[159-k]`. The pixel at column c and row r is at index c*8 + r, and row 0 is latched like any other row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the write clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the configuration words |
| wclk_i | input | 1 | Asynchronous serial write clock |
| wen_n_i | input | 1 | Asynchronous active-low write enable |
| tgt_ctl_i | input | 1 | Register target: 0 pixel, 1 control |
| sdata_i | input | 1 | Serial data input |
| sdata_o | output | 1 | Serial data output for chaining |
| dot_latch_o | output | 160 | Latched pixel image |
| cfg0_o | output | 7 | Configuration word 0 |
| cfg1_o | output | 7 | Configuration word 1; bit 0 enables pass-through |

## Verification
Two events can land in the same synchronised cycle: the enable fall that captures the target, and the first write-clock rise that shifts. The bench makes them meet by changing `wen_n_i` and `wclk_i` on the same system-clock edge, with the previous target being the pixel register. It then checks that all eight bits reached the control word and that the pixel latch is untouched. A second pairing is the enable rise while the write clock is still high. There the bench checks that no transfer happens until the clock falls.

// File: rtl/ledmx_pkg.sv
package ledmx_pkg;

  localparam int unsigned PIX_BITS_DEF = 160;
  localparam int unsigned PIX_ROWS_DEF = 8;
  localparam int unsigned CTL_BITS_DEF = 8;

  typedef enum logic {TGT_PIX = 1'b0, TGT_CTL = 1'b1} tgt_e;

  // flat latch index of a pixel given its column and row
  function automatic int unsigned pix_index(input int unsigned col,
                                            input int unsigned row,
                                            input int unsigned rows);
    return col * rows + row;
  endfunction

  // top bit of a control byte picks the word
  function automatic logic ctl_word_sel(input logic [CTL_BITS_DEF-1:0] b);
    return b[CTL_BITS_DEF-1];
  endfunction

  // payload of a control byte
  function automatic logic [CTL_BITS_DEF-2:0] ctl_payload(input logic [CTL_BITS_DEF-1:0] b);
    return b[CTL_BITS_DEF-2:0];
  endfunction

endpackage

// File: rtl/ledmx_edge_sync.sv
module ledmx_edge_sync #(
  parameter int unsigned W       = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [W-1:0] stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= async_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) stg[i] <= RST_VAL;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign lvl_o  = stg[STAGES-1];
  assign rise_o = stg[STAGES-1] & ~stg[STAGES];
  assign fall_o = ~stg[STAGES-1] & stg[STAGES];
endmodule

// File: rtl/ledmx_pix_path.sv
module ledmx_pix_path #(
  parameter int unsigned PIX_BITS = 160
) (
  input  logic                clk,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic                load_i,
  output logic                tail_o,
  output logic [PIX_BITS-1:0] latch_o
);
  logic [PIX_BITS-1:0] sr_q;
  logic [PIX_BITS-1:0] latch_q;

  // pixel storage is deliberately outside the reset domain
  always_ff @(posedge clk) begin
    if (shift_i) sr_q <= {sr_q[PIX_BITS-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (load_i) latch_q <= sr_q;
  end

  assign tail_o  = sr_q[PIX_BITS-1];
  assign latch_o = latch_q;
endmodule

// File: rtl/ledmx_ctl_path.sv
module ledmx_ctl_path
  import ledmx_pkg::*;
#(
  parameter int unsigned CTL_BITS = CTL_BITS_DEF
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_i,
  input  logic                bit_i,
  input  logic                load_i,
  output logic                tail_o,
  output logic                to_word1_o,
  output logic [CTL_BITS-2:0] cfg0_o,
  output logic [CTL_BITS-2:0] cfg1_o
);
  localparam int unsigned WW = CTL_BITS - 1;

  logic [CTL_BITS-1:0] sr_q;
  logic [WW-1:0]       w0_q, w1_q;
  logic                sel1;

  assign sel1 = ctl_word_sel(sr_q);

  always_ff @(posedge clk) begin
    if (!rst_n)       sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[CTL_BITS-2:0], bit_i};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
    end else if (load_i) begin
      if (sel1) w1_q <= ctl_payload(sr_q);
      else      w0_q <= ctl_payload(sr_q);
    end
  end

  assign tail_o     = sr_q[CTL_BITS-1];
  assign to_word1_o = sel1;
  assign cfg0_o     = w0_q;
  assign cfg1_o     = w1_q;
endmodule

// File: rtl/ledmx_serial_rx.sv
module ledmx_serial_rx
  import ledmx_pkg::*;
#(
  parameter int unsigned PIX_BITS    = PIX_BITS_DEF,
  parameter int unsigned CTL_BITS    = CTL_BITS_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wclk_i,
  input  logic                wen_n_i,
  input  logic                tgt_ctl_i,
  input  logic                sdata_i,
  output logic                sdata_o,
  output logic [PIX_BITS-1:0] dot_latch_o,
  output logic [CTL_BITS-2:0] cfg0_o,
  output logic [CTL_BITS-2:0] cfg1_o
);
  localparam int unsigned NIN = 4;
  // bit order: {sdata, tgt, wen_n, wclk}; idle levels clock low, enable high
  localparam logic [NIN-1:0] IDLE = 4'b0010;

  logic [NIN-1:0] lvl, rise, fall;
  logic wclk_l, wen_l, tgt_l, dat_l;

  ledmx_edge_sync #(.W(NIN), .STAGES(SYNC_STAGES), .RST_VAL(IDLE)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sdata_i, tgt_ctl_i, wen_n_i, wclk_i}),
    .lvl_o   (lvl),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  assign wclk_l = lvl[0];
  assign wen_l  = lvl[1];
  assign tgt_l  = lvl[2];
  assign dat_l  = lvl[3];

  // named events
  logic wen_fall_evt, wclk_rise_evt;
  logic shift_evt, shift_pix, shift_ctl;
  logic xfer_evt, pix_load, ctl_load;
  tgt_e tgt_q, tgt_now;
  logic pend_q;

  assign wen_fall_evt  = rst_n & fall[1];
  assign wclk_rise_evt = rst_n & rise[0];

  // a rise coinciding with the enable fall uses the fresh target
  assign tgt_now   = wen_fall_evt ? tgt_e'(tgt_l) : tgt_q;
  assign shift_evt = wclk_rise_evt & ~wen_l;
  assign shift_pix = shift_evt & (tgt_now == TGT_PIX);
  assign shift_ctl = shift_evt & (tgt_now == TGT_CTL);

  assign xfer_evt = rst_n & pend_q & wen_l & ~wclk_l;
  assign pix_load = xfer_evt & (tgt_q == TGT_PIX);
  assign ctl_load = xfer_evt & (tgt_q == TGT_CTL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_q  <= TGT_PIX;
      pend_q <= 1'b0;
    end else begin
      if (wen_fall_evt) begin
        tgt_q  <= tgt_e'(tgt_l);
        pend_q <= 1'b1;
      end else if (xfer_evt) begin
        pend_q <= 1'b0;
      end
    end
  end

  logic pix_tail, ctl_tail, ctl_to_w1;

  ledmx_pix_path #(.PIX_BITS(PIX_BITS)) u_pix (
    .clk     (clk),
    .shift_i (shift_pix),
    .bit_i   (dat_l),
    .load_i  (pix_load),
    .tail_o  (pix_tail),
    .latch_o (dot_latch_o)
  );

  ledmx_ctl_path #(.CTL_BITS(CTL_BITS)) u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .shift_i    (shift_ctl),
    .bit_i      (dat_l),
    .load_i     (ctl_load),
    .tail_o     (ctl_tail),
    .to_word1_o (ctl_to_w1),
    .cfg0_o     (cfg0_o),
    .cfg1_o     (cfg1_o)
  );

  // output mux: pass-through only during an active control write
  logic ctl_wr_active, pass_act;
  assign ctl_wr_active = (tgt_q == TGT_CTL) & ~wen_l;
  assign pass_act      = cfg1_o[0] & ctl_wr_active;

  always_comb begin
    if (pass_act)              sdata_o = sdata_i;
    else if (tgt_q == TGT_CTL) sdata_o = ctl_tail;
    else                       sdata_o = pix_tail;
  end
endmodule

// File: rtl/ledmx_serial_rx_chk.sv
module ledmx_serial_rx_chk #(
  parameter int unsigned PIX_BITS = 160,
  parameter int unsigned CTL_BITS = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                sdata_i,
  input logic                sdata_o,
  input logic [PIX_BITS-1:0] dot_latch_o,
  input logic [CTL_BITS-2:0] cfg0_o,
  input logic [CTL_BITS-2:0] cfg1_o,
  input logic                shift_evt,
  input logic                pix_load,
  input logic                ctl_load,
  input logic                ctl_to_w1,
  input logic                ctl_wr_active
);
  logic rst_seen;
  always_ff @(posedge clk) rst_seen <= rst_n;

  // R5: one edge after reset is applied both words read zero
  always_ff @(posedge clk) begin
    if (rst_seen === 1'b0)
      a_r5_cfg_cleared: assert (cfg0_o == '0 && cfg1_o == '0)
        else $error("cfg words not cleared by reset");
  end

  // R3: shift and the two transfer kinds never share a cycle
  a_r3_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_evt, pix_load, ctl_load}));

  // R8: latch only moves on a pixel transfer
  a_r8_latch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_load |=> $stable(dot_latch_o));

  // R4: the unselected word keeps its value
  a_r4_keep_word1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_load && !ctl_to_w1) |=> $stable(cfg1_o));
  a_r4_keep_word0: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_load && ctl_to_w1) |=> $stable(cfg0_o));

  // R7: pass-through copies the input during control writes
  a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg1_o[0] && ctl_wr_active) |-> (sdata_o == sdata_i));
endmodule

bind ledmx_serial_rx ledmx_serial_rx_chk #(.PIX_BITS(PIX_BITS), .CTL_BITS(CTL_BITS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sdata_i       (sdata_i),
  .sdata_o       (sdata_o),
  .dot_latch_o   (dot_latch_o),
  .cfg0_o        (cfg0_o),
  .cfg1_o        (cfg1_o),
  .shift_evt     (shift_evt),
  .pix_load      (pix_load),
  .ctl_load      (ctl_load),
  .ctl_to_w1     (ctl_to_w1),
  .ctl_wr_active (ctl_wr_active)
);

// File: tb/ledmx_serial_rx_tb.sv
module ledmx_serial_rx_tb;
  localparam int NPIX = 160;
  localparam int NROW = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wclk = 1'b0, wen_n = 1'b1, tgt = 1'b0, sdi = 1'b0;
  logic sdo;
  logic [NPIX-1:0] latch;
  logic [6:0] c0, c1;

  always #2 clk = ~clk;

  ledmx_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .wclk_i(wclk), .wen_n_i(wen_n),
    .tgt_ctl_i(tgt), .sdata_i(sdi), .sdata_o(sdo),
    .dot_latch_o(latch), .cfg0_o(c0), .cfg1_o(c1)
  );

  int checks = 0;
  int errors = 0;

  task automatic chk(input string req, input logic [NPIX-1:0] act, input logic [NPIX-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_write(input logic to_ctl);
    tgt = to_ctl; waitn(HALF);
    wen_n = 1'b0; waitn(HALF);
  endtask

  task automatic put_bit(input logic b);
    sdi = b; waitn(HALF);
    wclk = 1'b1; waitn(HALF);
    wclk = 1'b0;
  endtask

  task automatic end_write();
    waitn(HALF);
    wen_n = 1'b1; waitn(2*HALF);
  endtask

  task automatic write_ctl(input logic [7:0] b);
    start_write(1'b1);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    end_write();
  endtask

  task automatic write_pix(input logic [NPIX-1:0] seq);
    start_write(1'b0);
    for (int k = 0; k < NPIX; k++) put_bit(seq[k]);
    end_write();
  endtask

  function automatic logic [NPIX-1:0] rev(input logic [NPIX-1:0] s);
    logic [NPIX-1:0] r;
    for (int k = 0; k < NPIX; k++) r[NPIX-1-k] = s[k];
    return r;
  endfunction

  // {control byte, expected word0, expected word1}
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {8'h4D, 7'h4D, 7'h00},
    {8'h82, 7'h4D, 7'h02},
    {8'h3F, 7'h3F, 7'h02},
    {8'hFE, 7'h3F, 7'h7E},
    {8'h00, 7'h00, 7'h7E},
    {8'h80, 7'h00, 7'h00}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [NPIX-1:0] seq_a, seq_b, hold;
    waitn(5);
    rst_n = 1'b1;
    waitn(5);
    chk("R5 reset cfg0", NPIX'(c0), '0);
    chk("R5 reset cfg1", NPIX'(c1), '0);

    // R4 table of control writes
    for (int v = 0; v < NV; v++) begin
      write_ctl(VEC[v][21:14]);
      chk("R4 cfg0", NPIX'(c0), NPIX'(VEC[v][13:7]));
      chk("R4 cfg1", NPIX'(c1), NPIX'(VEC[v][6:0]));
    end

    // R9 single pixel at column 3 row 5
    seq_a = '0;
    seq_a[NPIX-1-(3*NROW+5)] = 1'b1;
    write_pix(seq_a);
    chk("R9 pixel c3 r5", latch, NPIX'(1) << (3*NROW+5));

    // R8 latch held during a new frame
    for (int k = 0; k < NPIX; k++) seq_a[k] = ((k*37+11) % 7) < 3;
    write_pix(seq_a);
    chk("R9 frame order", latch, rev(seq_a));
    seq_b = ~seq_a;
    start_write(1'b0);
    for (int k = 0; k < 80; k++) put_bit(seq_b[k]);
    waitn(2);
    chk("R8 latch held mid-shift", latch, rev(seq_a));
    for (int k = 80; k < NPIX; k++) put_bit(seq_b[k]);
    end_write();
    chk("R8 latch after transfer", latch, rev(seq_b));

    // R2 rises with enable high are ignored
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      waitn(HALF); wclk = 1'b1; waitn(HALF); wclk = 1'b0;
    end
    start_write(1'b0);
    end_write();
    chk("R2 no shift with enable high", latch, rev(seq_b));

    // R6 serial tail for pixel writes
    start_write(1'b0);
    chk("R6 tail before shift", NPIX'(sdo), NPIX'(seq_b[0]));
    put_bit(1'b0);
    waitn(2);
    chk("R6 tail after one shift", NPIX'(sdo), NPIX'(seq_b[1]));
    end_write();

    // R5 reset keeps latch
    write_ctl(8'h15);
    write_ctl(8'h84);
    hold = latch;
    rst_n = 1'b0; waitn(3); rst_n = 1'b1; waitn(2);
    chk("R5 cfg0 cleared", NPIX'(c0), '0);
    chk("R5 cfg1 cleared", NPIX'(c1), '0);
    chk("R5 latch kept", latch, hold);

    // R6 control tail is D7 after eight bits
    start_write(1'b1);
    for (int i = 7; i >= 0; i--) put_bit(8'hA4 >> i);
    waitn(2);
    chk("R6 control tail", NPIX'(sdo), NPIX'(1'b1));
    end_write();
    chk("R4 cfg1 A4", NPIX'(c1), NPIX'(7'h24));

    // R1 select change during a write is ignored
    start_write(1'b1);
    for (int i = 7; i >= 4; i--) put_bit(8'h11 >> i);
    tgt = 1'b0;
    for (int i = 3; i >= 0; i--) put_bit(8'h11 >> i);
    end_write();
    chk("R1 cfg0 kept target", NPIX'(c0), NPIX'(7'h11));
    chk("R1 latch untouched", latch, hold);

    // R3 enable rises while clock high: transfer waits for clock fall
    start_write(1'b1);
    for (int i = 7; i >= 1; i--) put_bit(8'h22 >> i);
    sdi = 1'b0; waitn(HALF); wclk = 1'b1; waitn(HALF);
    wen_n = 1'b1; waitn(2*HALF);
    chk("R3 no transfer while clock high", NPIX'(c0), NPIX'(7'h11));
    wclk = 1'b0; waitn(2*HALF);
    chk("R3 transfer on clock fall", NPIX'(c0), NPIX'(7'h22));

    // R1 collision: enable fall and first rise together, previous target pixel
    write_pix(seq_a);
    tgt = 1'b1; waitn(HALF);
    sdi = 1'b1; wen_n = 1'b0; wclk = 1'b1; waitn(HALF);
    wclk = 1'b0;
    for (int i = 6; i >= 0; i--) put_bit(8'h85 >> i);
    end_write();
    chk("R1 collision cfg1", NPIX'(c1), NPIX'(7'h05));
    chk("R1 collision cfg0 kept", NPIX'(c0), NPIX'(7'h22));
    chk("R1 collision latch kept", latch, rev(seq_a));

    // R7 pass-through on control writes only
    start_write(1'b1);
    sdi = 1'b0; #1;
    chk("R7 follow 0", NPIX'(sdo), NPIX'(1'b0));
    sdi = 1'b1; #1;
    chk("R7 follow 1", NPIX'(sdo), NPIX'(1'b1));
    for (int i = 7; i >= 0; i--) put_bit(8'h80 >> i);
    end_write();
    chk("R7 cfg1 cleared by write", NPIX'(c1), '0);
    write_ctl(8'h81);
    start_write(1'b0);
    sdi = ~seq_a[0]; #1;
    chk("R7 pixel write stays serial", NPIX'(sdo), NPIX'(seq_a[0]));
    wen_n = 1'b1; waitn(2*HALF);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule